// File: doc/BRIEF.md
# Program Counter Sequencer with Hardware Return Stack

This block holds the 13-bit program counter of a small microcontroller core and decides its next value every clock. The instruction decoder selects one of four actions through a one-hot operation field: step to the next address, call a subroutine, return from a subroutine, or return from an interrupt. The interrupt controller can also assert a take strobe. That strobe diverts the core to a fixed service vector.

Return addresses for subroutines and for interrupt service share one eight-slot hardware stack. A call saves the address that follows the call. An interrupt saves the address of the instruction it preempted. Both kinds of return pop the most recent slot. A call target has two parts: an 11-bit literal supplies the low bits, and two bits of a paging register supply the top bits. The stack never stalls. A push beyond its capacity overwrites the oldest slot, and a pop with nothing saved reads a stale slot. Each of these two conditions sets its own sticky flag.

Top module: `pc_call_stack`

## Requirements
- R1: While rst_ni is low and after it rises, pc_o is 0x000, depth_o is 0, and overflow_o and underflow_o are 0.
- R2: op_i is one-hot with these bits: bit0 increment, bit1 call, bit2 return, bit3 return-from-interrupt. An increment wraps modulo 8192. With op_i all zero and no interrupt, every output holds. When several bits are set, priority runs from bit1 to bit2 to bit3 to bit0.
- R3: A call loads pc_o with {page_reg_i[4:3], lit_i[10:0]} on the next clock.
- R4: A call pushes pc_o+1 (modulo 8192) and increments depth_o.
- R5: A return pops the newest saved address into pc_o and decrements depth_o. Nested calls therefore unwind in last-in-first-out order.
- R6: A return-from-interrupt behaves exactly like a return.
- R7: When irq_take_i is high, the block pushes the current pc_o and loads 0x004, regardless of op_i. The preempted address is saved, not pc_o+1.
- R8: Subroutine and interrupt return addresses interleave on the same stack in order of entry.
- R9: A push with depth_o equal to 8 overwrites the oldest slot and leaves depth_o at 8. It also sets overflow_o.
- R10: A pop with depth_o equal to 0 leaves depth_o at 0 and sets underflow_o. The stack pointer steps back modulo 8, and pc_o takes the content of that slot.
- R11: overflow_o and underflow_o stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | One-hot operation select |
| lit_i | input | 11 | Call target literal |
| page_reg_i | input | 5 | Paging register; bits 4:3 form the target's top bits |
| irq_take_i | input | 1 | Interrupt take strobe |
| pc_o | output | 13 | Current program counter |
| depth_o | output | 4 | Number of valid stack slots, 0 to 8 |
| overflow_o | output | 1 | Sticky stack overflow flag |
| underflow_o | output | 1 | Sticky stack underflow flag |

## Verification
The hardest state to reach is the stack after it has wrapped. There, the oldest return address has been lost, and a later pop on an empty stack has to read the slot that the wrapped pointer lands on. The stimulus first issues nine nested calls with distinct targets. It then unwinds all eight surviving levels and pops once more, and a behavioural model of pointer and slot contents predicts every address. Interrupts are also raised inside subroutines and in the same cycle as a call, so the mixed ordering on the shared stack is exercised.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned OP_W     = 4;
  localparam int unsigned OP_INC   = 0;
  localparam int unsigned OP_CALL  = 1;
  localparam int unsigned OP_RET   = 2;
  localparam int unsigned OP_RETI  = 3;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_INC,
    ACT_CALL,
    ACT_POP,
    ACT_IRQ
  } pcs_act_e;
endpackage

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
  import pcs_pkg::*;
#(
  parameter int unsigned PC_W  = 13,
  parameter int unsigned LIT_W = 11,
  parameter logic [PC_W-1:0] VECTOR = 13'h004
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [LIT_W-1:0] lit_i,
  input  logic [PC_W-9:0]  page_reg_i,
  input  logic             irq_i,
  input  logic [PC_W-1:0]  top_i,
  output pcs_act_e         act_o,
  output logic [PC_W-1:0]  push_data_o,
  output logic [PC_W-1:0]  pc_d_o
);
  localparam int unsigned PG_W  = PC_W - LIT_W;
  localparam int unsigned PG_HI = PC_W - 9;

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] call_tgt;

  assign pc_inc   = pc_i + PC_W'(1);
  assign call_tgt = {page_reg_i[PG_HI -: PG_W], lit_i};

  always_comb begin
    if (irq_i)                                    act_o = ACT_IRQ;
    else if (op_i[OP_CALL])                       act_o = ACT_CALL;
    else if (op_i[OP_RET] || op_i[OP_RETI])       act_o = ACT_POP;
    else if (op_i[OP_INC])                        act_o = ACT_INC;
    else                                          act_o = ACT_HOLD;
  end

  always_comb begin
    push_data_o = pc_inc;
    pc_d_o      = pc_i;
    unique case (act_o)
      ACT_IRQ:  begin push_data_o = pc_i; pc_d_o = VECTOR; end
      ACT_CALL: pc_d_o = call_tgt;
      ACT_POP:  pc_d_o = top_i;
      ACT_INC:  pc_d_o = pc_inc;
      default:  pc_d_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int unsigned DATA_W = 13,
  parameter int unsigned DEPTH  = 8   // power of two: pointer wraps modulo DEPTH
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic [DATA_W-1:0]          top_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic                       ovf_o,
  output logic                       unf_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_dn;
  logic [CNT_W-1:0]  cnt_q;

  assign ptr_dn = ptr_q - PTR_W'(1);
  assign top_o  = mem_q[ptr_dn];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (push_i && ptr_q == PTR_W'(g))      mem_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else if (push_i) begin
      ptr_q <= ptr_q + PTR_W'(1);
      if (cnt_q == CNT_W'(DEPTH)) ovf_o <= 1'b1;
      else                        cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i) begin
      ptr_q <= ptr_dn;
      if (cnt_q == '0) unf_o <= 1'b1;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign depth_o = cnt_q;
endmodule

// File: rtl/pc_call_stack.sv
module pc_call_stack
  import pcs_pkg::*;
#(
  parameter int unsigned PC_W  = 13,
  parameter int unsigned LIT_W = 11,
  parameter int unsigned DEPTH = 8,
  parameter logic [PC_W-1:0] VECTOR = 13'h004
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [OP_W-1:0]            op_i,
  input  logic [LIT_W-1:0]           lit_i,
  input  logic [PC_W-9:0]            page_reg_i,
  input  logic                       irq_take_i,
  output logic [PC_W-1:0]            pc_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic                       overflow_o,
  output logic                       underflow_o
);
  pcs_act_e        act;
  logic [PC_W-1:0] pc_q, pc_d, push_data, top;
  logic            push, pop;

  assign push = (act == ACT_CALL) || (act == ACT_IRQ);
  assign pop  = (act == ACT_POP);

  pcs_next_pc #(.PC_W(PC_W), .LIT_W(LIT_W), .VECTOR(VECTOR)) i_next (
    .pc_i        (pc_q),
    .op_i        (op_i),
    .lit_i       (lit_i),
    .page_reg_i  (page_reg_i),
    .irq_i       (irq_take_i),
    .top_i       (top),
    .act_o       (act),
    .push_data_o (push_data),
    .pc_d_o      (pc_d)
  );

  pcs_stack #(.DATA_W(PC_W), .DEPTH(DEPTH)) i_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .data_i  (push_data),
    .top_o   (top),
    .depth_o (depth_o),
    .ovf_o   (overflow_o),
    .unf_o   (underflow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int unsigned PC_W  = 13,
  parameter int unsigned LIT_W = 11,
  parameter int unsigned DEPTH = 8,
  parameter logic [PC_W-1:0] VECTOR = 13'h004
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [3:0]                 op_i,
  input logic [LIT_W-1:0]           lit_i,
  input logic [PC_W-9:0]            page_reg_i,
  input logic                       irq_take_i,
  input logic [PC_W-1:0]            pc_o,
  input logic [$clog2(DEPTH+1)-1:0] depth_o,
  input logic                       overflow_o,
  input logic                       underflow_o
);
  localparam int unsigned PG_W  = PC_W - LIT_W;
  localparam int unsigned PG_HI = PC_W - 9;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic is_call, is_pop, is_inc;
  assign is_call = !irq_take_i && op_i[1];
  assign is_pop  = !irq_take_i && !op_i[1] && (op_i[2] || op_i[3]);
  assign is_inc  = !irq_take_i && op_i == 4'b0001;

  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_inc |=> pc_o == $past(pc_o) + PC_W'(1)); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_take_i && op_i == 4'b0000) |=> $stable(pc_o) && $stable(depth_o)); // R2
  AST_CALL_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_call |=> pc_o == {$past(page_reg_i[PG_HI -: PG_W]), $past(lit_i)}); // R3
  AST_CALL_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_call && depth_o != CNT_W'(DEPTH)) |=> depth_o == $past(depth_o) + CNT_W'(1)); // R4
  AST_POP_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pop && depth_o != '0) |=> depth_o == $past(depth_o) - CNT_W'(1)); // R5
  AST_IRQ_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i |=> pc_o == VECTOR); // R7
  AST_DEPTH_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= CNT_W'(DEPTH)); // R9
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_take_i || op_i[1]) && depth_o == CNT_W'(DEPTH)) |=> overflow_o && depth_o == CNT_W'(DEPTH)); // R9
  AST_UNF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pop && depth_o == '0) |=> underflow_o && depth_o == '0); // R10
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R11
  AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o); // R11
endmodule

bind pc_call_stack pcs_checker #(
  .PC_W(PC_W), .LIT_W(LIT_W), .DEPTH(DEPTH), .VECTOR(VECTOR)
) i_pcs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .lit_i       (lit_i),
  .page_reg_i  (page_reg_i),
  .irq_take_i  (irq_take_i),
  .pc_o        (pc_o),
  .depth_o     (depth_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/test_pc_call_stack.sv
module test_pc_call_stack;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [10:0] lit_i = '0;
  logic [4:0]  page_reg_i = '0;
  logic        irq_take_i = 1'b0;
  logic [12:0] pc_o;
  logic [3:0]  depth_o;
  logic        overflow_o, underflow_o;

  int n_vec = 0;
  int n_bad = 0;

  // behavioural reference
  int m_pc, m_ptr, m_depth;
  int m_mem [DEPTH];
  bit m_ovf, m_unf;

  always #5 clk_i = ~clk_i;

  pc_call_stack i_pc_call_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .lit_i(lit_i),
    .page_reg_i(page_reg_i), .irq_take_i(irq_take_i), .pc_o(pc_o),
    .depth_o(depth_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  task automatic model_reset();
    m_pc = 0; m_ptr = 0; m_depth = 0; m_ovf = 0; m_unf = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
  endtask

  task automatic model_push(int v);
    m_mem[m_ptr] = v;
    m_ptr = (m_ptr + 1) % DEPTH;
    if (m_depth == DEPTH) m_ovf = 1; else m_depth++;
  endtask

  task automatic model_pop();
    m_ptr = (m_ptr + DEPTH - 1) % DEPTH;
    m_pc = m_mem[m_ptr];
    if (m_depth == 0) m_unf = 1; else m_depth--;
  endtask

  task automatic compare(string tag);
    n_vec++;
    if (pc_o !== 13'(m_pc) || depth_o !== 4'(m_depth) ||
        overflow_o !== m_ovf || underflow_o !== m_unf) begin
      n_bad++;
      $display("FAIL %s: pc=%h depth=%0d ovf=%b unf=%b, expected pc=%h depth=%0d ovf=%b unf=%b",
               tag, pc_o, depth_o, overflow_o, underflow_o, 13'(m_pc), m_depth, m_ovf, m_unf);
    end
  endtask

  task automatic step(logic [3:0] op, int lit, int page, bit irq, string tag);
    @(negedge clk_i);
    op_i = op; lit_i = 11'(lit); page_reg_i = 5'(page); irq_take_i = irq;
    if (irq) begin
      model_push(m_pc); m_pc = 4;
    end else if (op[1]) begin
      model_push((m_pc + 1) % 8192);
      m_pc = ((page >> 3) & 3) * 2048 + (lit & 2047);
    end else if (op[2] || op[3]) model_pop();
    else if (op[0]) m_pc = (m_pc + 1) % 8192;
    @(posedge clk_i);
    #1;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; op_i = '0; irq_take_i = 1'b0;
    model_reset();
    #1 compare("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1 compare("R1");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();

    // sequential stepping, hold, priority of several bits
    for (int i = 0; i < 5; i++) step(4'b0001, 0, 0, 0, "R2");
    step(4'b0000, 0, 0, 0, "R2");
    step(4'b0000, 0, 0, 0, "R2");

    // nested subroutines: aa -> bb -> ee, unwind LIFO
    step(4'b0010, 11'h123, 5'b10000, 0, "R3");
    step(4'b0001, 0, 0, 0, "R2");
    step(4'b0011, 11'h7A5, 5'b01000, 0, "R4");
    step(4'b0001, 0, 0, 0, "R2");
    step(4'b0100, 0, 0, 0, "R5");
    step(4'b0001, 0, 0, 0, "R2");
    step(4'b1100, 0, 0, 0, "R5");

    // interrupt inside subroutine, mixed unwinding
    step(4'b0010, 11'h040, 5'b11000, 0, "R4");
    step(4'b0001, 0, 0, 0, "R2");
    step(4'b0001, 0, 0, 1, "R7");
    step(4'b0001, 0, 0, 0, "R2");
    step(4'b0010, 11'h200, 5'b00000, 0, "R8");
    step(4'b0100, 0, 0, 0, "R8");
    step(4'b1000, 0, 0, 0, "R6");
    step(4'b0100, 0, 0, 0, "R8");

    // interrupt and call in the same cycle
    step(4'b0010, 11'h333, 5'b01000, 1, "R7");
    step(4'b1000, 0, 0, 0, "R6");

    // increment wrap at top of space
    step(4'b0010, 11'h7FF, 5'b11000, 0, "R3");
    step(4'b0001, 0, 0, 0, "R2");
    step(4'b0100, 0, 0, 0, "R5");

    // nine nested pushes then full unwind and one extra pop
    for (int i = 0; i < 9; i++) step(4'b0010, 11'h100 + 16 * i, 5'(i << 3), 0, "R9");
    for (int i = 0; i < 8; i++) step(4'b0100, 0, 0, 0, "R9");
    step(4'b0100, 0, 0, 0, "R10");
    step(4'b1000, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(4'b0010, 11'h055, 0, 0, "R11");
    step(4'b0001, 0, 0, 1, "R11");

    // pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      int unsigned r = $urandom;
      step(4'(r), int'(r >> 8), int'(r >> 20), (r[31:28] == 4'hF), "R8");
    end

    do_reset();
    step(4'b0001, 0, 0, 0, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule